// File: doc/BRIEF.md
# T1 Channel Timing Generator

This block produces the timing strobes for a 1.544 Mb/s T1 stream. It runs one bit per clock cycle and keeps two counters. The first is the bit position inside a 193-bit frame: the framing bit, then 24 channels of 8 bits each. The second is the frame number inside a multiframe of 12 frames or 24 frames.

From these two counters the block decodes the following outputs:
- a channel clock;
- a per-channel block line driven from a 24-bit mask;
- a frame pulse;
- a sync pulse that can be set to mark frames or multiframes;
- a link clock at half the frame rate;
- a link-data update strobe.

An upstream framer that has found alignment realigns the counters with a frame-start pulse or a multiframe-start pulse. This block does no data handling and has no handshaking. All of its pins are plain control and status levels or pulses, so there is no back-pressure. All outputs are decoded from the registered counters and the present control levels.

Top module: `t1_chan_timing`

## Requirements
- R1: After reset, the first bit is the framing bit of frame 1. At that bit `fsync_out`=1, `sync_out`=1 (frame mode), `link_clk`=1, and `chan_clk`, `chan_blk` and `link_upd` are 0.
- R2: A frame is 193 bits. Position 0 is the framing bit, and channel k (0..23) takes positions 1+8k to 8+8k. `fsync_out` is 1 exactly at position 0 of every frame, whatever the mode inputs are.
- R3: `chan_clk` is 1 only at the eighth (least significant, last sent) bit of each channel, that is positions 8, 16, …, 192. It is never 1 on the framing bit.
- R4: During the bits of channel k, `chan_blk` equals `blk_mask[k]`; mask bit 0 belongs to the first channel sent. `chan_blk` is 0 on the framing bit.
- R5: With `sync_mf_sel`=0, `sync_out` is 1 at position 0 of every frame. When `sync_dbl_en`=1, it is also 1 at position 1 of signaling frames, so the pulse is two bits wide there. Signaling frames are frames whose number is a multiple of 6: 6 and 12 with 12-frame multiframes, and 6, 12, 18 and 24 with 24-frame multiframes.
- R6: With `sync_mf_sel`=1, `sync_out` is 1 only at position 0 of frame 1, and `sync_dbl_en` has no effect.
- R7: With `esf_mode`=0 the multiframe is 12 frames; with `esf_mode`=1 it is 24 frames. If the counter is already past the end of the selected length, the next frame boundary returns it to frame 1.
- R8: `link_clk` is 1 for the whole of each odd-numbered frame and 0 for even-numbered frames. `link_upd` is 1 at position 192 of every even-numbered frame, one bit before an odd frame begins.
- R9: A `frame_start` pulse makes the next bit the framing bit of the next frame number, following the R7 wrap rule.
- R10: A `mf_start` pulse makes the next bit the framing bit of frame 1. It overrides `frame_start` when both are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one T1 bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Realign: next bit is a framing bit |
| mf_start | input | 1 | Realign: next bit is framing bit of frame 1 |
| esf_mode | input | 1 | 0: 12-frame multiframe, 1: 24-frame multiframe |
| sync_mf_sel | input | 1 | 0: sync marks frames, 1: sync marks multiframes |
| sync_dbl_en | input | 1 | Double-wide sync on signaling frames (frame mode only) |
| blk_mask | input | 24 | Per-channel block level, bit k for channel k |
| chan_clk | output | 1 | High on the last bit of each channel |
| chan_blk | output | 1 | Mask bit of the current channel |
| sync_out | output | 1 | Frame or multiframe sync pulse |
| fsync_out | output | 1 | Frame pulse on every framing bit |
| link_clk | output | 1 | Half-frame-rate link clock |
| link_upd | output | 1 | Link data update strobe |

## Verification
The main coincidence is a realignment pulse that arrives in the same cycle as the counter's own end-of-frame wrap. Position 192 also carries `chan_clk` and, in even frames, `link_upd`. The bench walks its reference model to position 192 and asserts `frame_start` or `mf_start` in exactly that cycle. It then expects the frame number to advance only once and the strobes of that last bit to appear unchanged. A second coincidence is tested by asserting both pulses together, where the bench expects frame 1 to win.

// File: rtl/t1tg_pkg.sv
package t1tg_pkg;
  typedef enum logic {
    SYNC_PER_FRAME  = 1'b0,
    SYNC_PER_MFRAME = 1'b1
  } sync_sel_e;
endpackage

// File: rtl/t1tg_bit_ctr.sv
module t1tg_bit_ctr #(
  parameter int FRAME_BITS = 193,
  parameter int BW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          realign,
  output logic [BW-1:0] bpos,
  output logic          last_bit,
  output logic          wrap
);
  assign last_bit = (int'(bpos) == FRAME_BITS - 1);
  assign wrap     = last_bit | realign;

  always_ff @(posedge clk) begin
    if (!rst_n)    bpos <= '0;
    else if (wrap) bpos <= '0;
    else           bpos <= bpos + BW'(1);
  end
endmodule

// File: rtl/t1tg_frame_ctr.sv
module t1tg_frame_ctr #(
  parameter int MF_SHORT = 12,
  parameter int MF_LONG  = 24,
  parameter int FW = $clog2(MF_LONG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          to_first,
  input  logic          long_mf,
  output logic [FW-1:0] fidx
);
  int flen;
  assign flen = long_mf ? MF_LONG : MF_SHORT;

  always_ff @(posedge clk) begin
    if (!rst_n || to_first)           fidx <= '0;
    else if (advance) begin
      if (int'(fidx) >= flen - 1)     fidx <= '0;
      else                            fidx <= fidx + FW'(1);
    end
  end
endmodule

// File: rtl/t1tg_strobe_dec.sv
module t1tg_strobe_dec
  import t1tg_pkg::*;
#(
  parameter int N_CH = 24,
  parameter int CH_BITS = 8,
  parameter int SIG_EVERY = 6,
  parameter int BW = 8,
  parameter int FW = 5
) (
  input  logic [BW-1:0]   bpos,
  input  logic [FW-1:0]   fidx,
  input  logic            last_bit,
  input  sync_sel_e       sel,
  input  logic            dbl_en,
  input  logic [N_CH-1:0] mask,
  output logic            chan_clk,
  output logic            chan_blk,
  output logic            sync_out,
  output logic            fsync_out,
  output logic            link_clk,
  output logic            link_upd
);
  logic [N_CH-1:0] in_ch;
  logic [N_CH-1:0] at_lsb;
  logic            sig_frame;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam int FIRST = 1 + k * CH_BITS;
    localparam int LAST  = FIRST + CH_BITS - 1;
    assign in_ch[k]  = (int'(bpos) >= FIRST) && (int'(bpos) <= LAST);
    assign at_lsb[k] = (int'(bpos) == LAST);
  end

  assign sig_frame = ((int'(fidx) + 1) % SIG_EVERY) == 0;
  assign chan_clk  = |at_lsb;
  assign chan_blk  = |(in_ch & mask);
  assign fsync_out = (bpos == '0);
  assign link_clk  = ~fidx[0];
  assign link_upd  = last_bit & fidx[0];

  always_comb begin
    if (sel == SYNC_PER_MFRAME)
      sync_out = fsync_out && (fidx == '0);
    else
      sync_out = fsync_out || (dbl_en && sig_frame && (int'(bpos) == 1));
  end
endmodule

// File: rtl/t1_chan_timing.sv
module t1_chan_timing
  import t1tg_pkg::*;
#(
  parameter int N_CH      = 24,
  parameter int CH_BITS   = 8,
  parameter int MF_SHORT  = 12,
  parameter int MF_LONG   = 24,
  parameter int SIG_EVERY = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            mf_start,
  input  logic            esf_mode,
  input  logic            sync_mf_sel,
  input  logic            sync_dbl_en,
  input  logic [N_CH-1:0] blk_mask,
  output logic            chan_clk,
  output logic            chan_blk,
  output logic            sync_out,
  output logic            fsync_out,
  output logic            link_clk,
  output logic            link_upd
);
  localparam int FRAME_BITS = 1 + N_CH * CH_BITS;
  localparam int BW = $clog2(FRAME_BITS);
  localparam int FW = $clog2(MF_LONG);

  logic [BW-1:0] bpos;
  logic [FW-1:0] fidx;
  logic          last_bit;
  logic          wrap;

  t1tg_bit_ctr #(.FRAME_BITS(FRAME_BITS), .BW(BW)) u_bit (
    .clk(clk), .rst_n(rst_n), .realign(frame_start | mf_start),
    .bpos(bpos), .last_bit(last_bit), .wrap(wrap)
  );

  t1tg_frame_ctr #(.MF_SHORT(MF_SHORT), .MF_LONG(MF_LONG), .FW(FW)) u_frm (
    .clk(clk), .rst_n(rst_n), .advance(wrap), .to_first(mf_start),
    .long_mf(esf_mode), .fidx(fidx)
  );

  t1tg_strobe_dec #(.N_CH(N_CH), .CH_BITS(CH_BITS), .SIG_EVERY(SIG_EVERY),
                    .BW(BW), .FW(FW)) u_dec (
    .bpos(bpos), .fidx(fidx), .last_bit(last_bit),
    .sel(sync_sel_e'(sync_mf_sel)), .dbl_en(sync_dbl_en), .mask(blk_mask),
    .chan_clk(chan_clk), .chan_blk(chan_blk), .sync_out(sync_out),
    .fsync_out(fsync_out), .link_clk(link_clk), .link_upd(link_upd)
  );
endmodule

// File: rtl/t1tg_chk.sv
module t1tg_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic mf_start,
  input logic sync_mf_sel,
  input logic chan_clk,
  input logic chan_blk,
  input logic sync_out,
  input logic fsync_out,
  input logic link_clk,
  input logic link_upd
);
  logic quiet;
  assign quiet = !frame_start && !mf_start;

  a_r2_fsync_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_out && quiet |=> !fsync_out);
  a_r3_chclk_not_framing: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clk |-> !fsync_out);
  a_r3_chclk_gap: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clk && quiet |=> !chan_clk);
  a_r4_blk_framing: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_out |-> !chan_blk);
  a_r6_mf_sync_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mf_sel && sync_out |-> fsync_out);
  a_r8_upd_before_odd: assert property (@(posedge clk) disable iff (!rst_n)
    link_upd && quiet |=> fsync_out && link_clk);
  a_r9_realign: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> fsync_out);
  a_r10_mf_first: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |=> fsync_out && link_clk);
endmodule

bind t1_chan_timing t1tg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mf_start(mf_start),
  .sync_mf_sel(sync_mf_sel), .chan_clk(chan_clk), .chan_blk(chan_blk),
  .sync_out(sync_out), .fsync_out(fsync_out), .link_clk(link_clk),
  .link_upd(link_upd)
);

// File: tb/t1_chan_timing_tb.sv
module t1_chan_timing_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, mf_start = 1'b0;
  logic esf_mode = 1'b0, sync_mf_sel = 1'b0, sync_dbl_en = 1'b0;
  logic [23:0] blk_mask = '0;
  logic chan_clk, chan_blk, sync_out, fsync_out, link_clk, link_upd;

  always #2.5 clk = ~clk;

  t1_chan_timing u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mf_start(mf_start),
    .esf_mode(esf_mode), .sync_mf_sel(sync_mf_sel), .sync_dbl_en(sync_dbl_en),
    .blk_mask(blk_mask), .chan_clk(chan_clk), .chan_blk(chan_blk),
    .sync_out(sync_out), .fsync_out(fsync_out), .link_clk(link_clk),
    .link_upd(link_upd)
  );

  typedef struct { logic [5:0] v; logic fs; logic ms; } exp_t;
  exp_t sbq[$];
  int checks = 0, errors = 0;
  int mb = 0, mf = 0;
  string phase = "";

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] bit=%0d frame=%0d actual=%0b expected=%0b",
               tag, phase, mb, mf + 1, act, exp);
    end
  endtask

  // expected {fsync, chan_clk, chan_blk, sync, link_clk, link_upd}
  function automatic logic [5:0] expect_at(int b, int f);
    logic fs_e, cc_e, cb_e, sy_e, lc_e, lu_e, sig;
    fs_e = (b == 0);
    cc_e = (b > 0) && (((b - 1) % 8) == 7);
    cb_e = (b > 0) && blk_mask[(b - 1) / 8];
    sig  = ((f + 1) % 6) == 0;
    sy_e = sync_mf_sel ? (b == 0 && f == 0) : (b == 0 || (sync_dbl_en && sig && b == 1));
    lc_e = (f % 2) == 0;
    lu_e = (b == 192) && (f % 2 == 1);
    return {fs_e, cc_e, cb_e, sy_e, lc_e, lu_e};
  endfunction

  task automatic drive(input logic fs, input logic ms);
    exp_t e;
    int len;
    frame_start = fs;
    mf_start = ms;
    len = esf_mode ? 24 : 12;
    if (ms) begin mb = 0; mf = 0; end
    else if (fs || mb == 192) begin
      mb = 0;
      mf = (mf + 1 >= len) ? 0 : mf + 1;
    end else mb++;
    e.v = expect_at(mb, mf);
    e.fs = fs;
    e.ms = ms;
    sbq.push_back(e);
  endtask

  task automatic monitor();
    exp_t e;
    e = sbq.pop_front();
    chk(fsync_out, e.v[5], "R2 fsync");
    chk(chan_clk,  e.v[4], "R3 chan_clk");
    chk(chan_blk,  e.v[3], "R4 chan_blk");
    chk(sync_out,  e.v[2], sync_mf_sel ? "R6 sync" : "R5 sync");
    chk(link_clk,  e.v[1], "R8 link_clk");
    chk(link_upd,  e.v[0], "R8 link_upd");
    if (e.ms) begin
      chk(fsync_out & link_clk, 1'b1, "R10 mf_start");
      chk(mf == 0, 1'b1, "R10 model frame 1");
    end else if (e.fs) chk(fsync_out, 1'b1, "R9 frame_start");
  endtask

  task automatic cyc(input logic fs, input logic ms);
    drive(fs, ms);
    @(negedge clk);
    frame_start = 1'b0;
    mf_start = 1'b0;
    monitor();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
  endtask

  task automatic goto_bit(input int b);
    while (mb != b) cyc(1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    blk_mask = 24'hA5_0F_81;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    phase = "reset";
    chk(fsync_out, 1'b1, "R1 fsync");
    chk(sync_out,  1'b1, "R1 sync");
    chk(link_clk,  1'b1, "R1 link_clk");
    chk(chan_clk,  1'b0, "R1 chan_clk");
    chk(chan_blk,  1'b0, "R1 chan_blk");
    chk(link_upd,  1'b0, "R1 link_upd");
    mb = 0; mf = 0;

    phase = "R5 d4 frame";
    run(2 * 12 * 193);
    phase = "R5 d4 double";
    sync_dbl_en = 1'b1;
    blk_mask = 24'h3C_C3_5A;
    run(12 * 193);
    phase = "R6 mf sel, dbl ignored";
    sync_mf_sel = 1'b1;
    run(12 * 193 + 10);
    phase = "R7 esf";
    esf_mode = 1'b1;
    blk_mask = 24'hFF_00_01;
    run(2 * 24 * 193);
    phase = "R5 esf double";
    sync_mf_sel = 1'b0;
    run(24 * 193);

    phase = "R9 mid-frame";
    goto_bit(50);
    cyc(1'b1, 1'b0);
    run(300);
    phase = "R10 mid-frame";
    goto_bit(77);
    cyc(1'b0, 1'b1);
    run(200);
    phase = "R10 both pulses";
    goto_bit(120);
    cyc(1'b1, 1'b1);
    run(200);
    phase = "R9 on natural wrap";
    goto_bit(192);
    cyc(1'b1, 1'b0);
    run(400);
    phase = "R10 on natural wrap";
    while (!(mb == 192 && mf % 2 == 1)) cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    run(200);

    phase = "R7 shrink";
    while (mf != 17) cyc(1'b0, 1'b0);
    esf_mode = 1'b0;
    run(3 * 193);
    chk(mf < 12, 1'b1, "R7 wrapped model");
    run(12 * 193);

    phase = "R4 mask flip";
    blk_mask = ~blk_mask;
    run(2 * 193);
    finish_run();
  end
endmodule